// File: doc/BRIEF.md
# System Clock Source Selector with Ready-Event Interrupts

This block is the control core of a small clock-control unit. Software picks the system clock source by writing a two-bit code: internal oscillator, external oscillator or PLL. Hardware can take that choice back. On a wake-up from a low-power state, or when clock supervision is on and the external oscillator is seen to fail while it drives the system clock (directly, or through the PLL), the code falls back to the internal oscillator. Software writes that try to select the one unused code are dropped.

A second register collects events. Each clock source has a ready flag that is set when its ready input rises. Each ready flag has a matching interrupt enable. A supervision-failure flag is always routed to the interrupt line and has no enable. Flags are cleared by writing ones to a clear field that always reads back as zero. Both registers sit on a simple write/read bus with byte-lane enables and no wait states. Reads are combinational on the address.

Top module: `clksw_ctrl`

## Requirements
- R1: After reset `sys_sel` is 00, `irq` is 0, and both registers read 0.
- R2: A write to offset 0x04 with lane 0 enabled loads `bus_wdata[1:0]` into the select code from the next cycle on. Codes are 00 internal, 01 external, 10 PLL. The code reads back in bits 1:0 of offset 0x04, and the other bits read 0.
- R3: A write of code 11 is ignored, and the previous code is kept.
- R4: A `lp_exit` pulse forces the code to 00 in the next cycle, even when a software write happens in the same cycle.
- R5: When `sec_en` and `fail_det` are both high, the code is forced to 00 if it is 01, or if it is 10 with `pll_on_ext` high. In every other case the code is left as it was.
- R6: Bits 6:0 of offset 0x08 are ready flags, one per `rdy_in` bit with bit 0 first. A flag is set by a 0-to-1 change of its input, and a held-high input does not set it again. Software writes to bits 7:0 have no effect.
- R7: Bit 7 of offset 0x08 is the failure flag. It is set by `fail_det` only while `sec_en` is high.
- R8: Bits 14:8 of offset 0x08 are read/write interrupt enables, one per ready flag in the same order. Bit 15 always reads 0.
- R9: Bits 22:16 clear the matching ready flags and bit 23 clears the failure flag. A written 0 has no effect. Bits 31:16 always read 0.
- R10: When a flag is set and cleared in the same cycle, it ends up set.
- R11: `irq` is high when any ready flag is high together with its enable, or when the failure flag is high.
- R12: Each byte lane of a write changes only the fields inside that lane, and only when its `bus_be` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rdy_in | input | NUM_SRC | Ready levels of the clock sources |
| fail_det | input | 1 | External oscillator failure pulse |
| sec_en | input | 1 | Clock supervision enable |
| pll_on_ext | input | 1 | PLL is fed by the external oscillator |
| lp_exit | input | 1 | Low-power exit pulse |
| sys_sel | output | 2 | Selected system clock code |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: seven sources, an 8-bit address, and edge-detected ready inputs. With these values every field of the event register is populated, so each of the seven enable/flag pairs can reach the interrupt line. The full-width layout also puts the clear field right next to the reserved top byte, so a write of all ones exercises that boundary. Because both offsets fit in the 8-bit address, random traffic can also hit an unmapped word.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

   typedef enum logic [1:0] {
      SRC_INT = 2'b00,
      SRC_EXT = 2'b01,
      SRC_PLL = 2'b10,
      SRC_BAD = 2'b11
   } clk_src_e;

   localparam int MAX_SRC  = 7;
   localparam int FAIL_POS = 7;
   localparam int EN_LSB   = 8;
   localparam int CLR_LSB  = 16;
   localparam int WORD_W   = 32;
   localparam int LANES    = WORD_W / 8;

endpackage

// File: rtl/clksw_srcsel.sv
module clksw_srcsel
   import clksw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sw_wr,
   input  logic [1:0] sw_code,
   input  logic       lp_exit,
   input  logic       fail_evt,
   input  logic       pll_on_ext,
   output logic [1:0] sel_o
);

   clk_src_e sel_q;
   clk_src_e sel_d;
   logic     ext_in_use;

   // The external oscillator drives the system clock either directly or through the PLL.
   assign ext_in_use = (sel_q == SRC_EXT) || ((sel_q == SRC_PLL) && pll_on_ext);

   always_comb begin
      sel_d = sel_q;
      if (sw_wr && (clk_src_e'(sw_code) != SRC_BAD))
         sel_d = clk_src_e'(sw_code);
      // Hardware fall-back overrides any software write in the same cycle.
      if (lp_exit || (fail_evt && ext_in_use))
         sel_d = SRC_INT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= SRC_INT;
      else        sel_q <= sel_d;
   end

   assign sel_o = sel_q;

endmodule

// File: rtl/clksw_flagbank.sv
module clksw_flagbank #(
   parameter int N    = 7,
   parameter bit EDGE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev_in,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);

   logic [N-1:0] set_ev;

   generate
      if (EDGE) begin : g_edge
         logic [N-1:0] ev_prev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ev_prev <= '0;
            else        ev_prev <= ev_in;
         end
         assign set_ev = ev_in & ~ev_prev;
      end else begin : g_level
         assign set_ev = ev_in;
      end
   endgenerate

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flag_q <= 1'b0;
            else if (set_ev[i]) flag_q <= 1'b1;  // set beats clear
            else if (clr[i])    flag_q <= 1'b0;
         end
         assign flags[i] = flag_q;
      end
   endgenerate

endmodule

// File: rtl/clksw_regif.sv
module clksw_regif
   import clksw_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int NUM_SRC = 7,
   parameter int SEL_OFS = 'h04,
   parameter int IRQ_OFS = 'h08
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [LANES-1:0]   bus_be,
   input  logic [WORD_W-1:0]  bus_wdata,
   input  logic [1:0]         sel,
   input  logic [NUM_SRC-1:0] flags,
   input  logic               fail_flag,
   output logic               sel_wr,
   output logic [1:0]         sel_code,
   output logic [NUM_SRC-1:0] en_q,
   output logic [NUM_SRC-1:0] clr_flags,
   output logic               clr_fail,
   output logic [WORD_W-1:0]  bus_rdata
);

   localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_OFS);
   localparam logic [ADDR_W-1:0] IRQ_A = ADDR_W'(IRQ_OFS);
   localparam int EN_LANE  = EN_LSB / 8;
   localparam int CLR_LANE = CLR_LSB / 8;

   logic sel_hit, irq_hit, clr_lane_wr;
   logic unused_wdata;

   assign sel_hit     = bus_wr && (bus_addr == SEL_A);
   assign irq_hit     = bus_wr && (bus_addr == IRQ_A);
   assign sel_wr      = sel_hit && bus_be[0];
   assign sel_code    = bus_wdata[1:0];
   assign clr_lane_wr = irq_hit && bus_be[CLR_LANE];
   assign clr_flags   = clr_lane_wr ? bus_wdata[CLR_LSB +: NUM_SRC] : '0;
   assign clr_fail    = clr_lane_wr && bus_wdata[CLR_LSB + FAIL_POS];
   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           en_q <= '0;
      else if (irq_hit && bus_be[EN_LANE])  en_q <= bus_wdata[EN_LSB +: NUM_SRC];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == SEL_A) begin
         bus_rdata[1:0] = sel;
      end else if (bus_addr == IRQ_A) begin
         bus_rdata[NUM_SRC-1:0]         = flags;
         bus_rdata[FAIL_POS]            = fail_flag;
         bus_rdata[EN_LSB +: NUM_SRC]   = en_q;
      end
   end

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
   import clksw_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int NUM_SRC  = 7,
   parameter int SEL_OFS  = 'h04,
   parameter int IRQ_OFS  = 'h08,
   parameter bit RDY_EDGE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [3:0]         bus_be,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_SRC-1:0] rdy_in,
   input  logic               fail_det,
   input  logic               sec_en,
   input  logic               pll_on_ext,
   input  logic               lp_exit,
   output logic [1:0]         sys_sel,
   output logic               irq
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_nsrc
         $error("clksw_ctrl: NUM_SRC out of range");
      end
      if (ADDR_W < 4 || ADDR_W > 16) begin : g_bad_aw
         $error("clksw_ctrl: ADDR_W out of range");
      end
      if (SEL_OFS == IRQ_OFS || SEL_OFS % 4 != 0 || IRQ_OFS % 4 != 0
          || SEL_OFS >= ADDR_SPAN || IRQ_OFS >= ADDR_SPAN) begin : g_bad_ofs
         $error("clksw_ctrl: register offsets invalid");
      end
   endgenerate

   logic               fail_evt;
   logic               sel_wr;
   logic [1:0]         sel_code;
   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] flags_q;
   logic [NUM_SRC-1:0] clr_flags;
   logic               clr_fail;
   logic               fail_q;

   assign fail_evt = sec_en && fail_det;

   clksw_srcsel u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_wr      (sel_wr),
      .sw_code    (sel_code),
      .lp_exit    (lp_exit),
      .fail_evt   (fail_evt),
      .pll_on_ext (pll_on_ext),
      .sel_o      (sys_sel)
   );

   clksw_flagbank #(.N(NUM_SRC), .EDGE(RDY_EDGE)) u_rdy (
      .clk   (clk),
      .rst_n (rst_n),
      .ev_in (rdy_in),
      .clr   (clr_flags),
      .flags (flags_q)
   );

   clksw_flagbank #(.N(1), .EDGE(1'b0)) u_fail (
      .clk   (clk),
      .rst_n (rst_n),
      .ev_in (fail_evt),
      .clr   (clr_fail),
      .flags (fail_q)
   );

   clksw_regif #(
      .ADDR_W (ADDR_W), .NUM_SRC(NUM_SRC),
      .SEL_OFS(SEL_OFS), .IRQ_OFS(IRQ_OFS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_be    (bus_be),
      .bus_wdata (bus_wdata),
      .sel       (sys_sel),
      .flags     (flags_q),
      .fail_flag (fail_q),
      .sel_wr    (sel_wr),
      .sel_code  (sel_code),
      .en_q      (en_q),
      .clr_flags (clr_flags),
      .clr_fail  (clr_fail),
      .bus_rdata (bus_rdata)
   );

   assign irq = (|(flags_q & en_q)) | fail_q;

endmodule

// File: rtl/clksw_ctrl_chk.sv
module clksw_ctrl_chk #(
   parameter int ADDR_W  = 8,
   parameter int SEL_OFS = 'h04
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [3:0]        bus_be,
   input logic [31:0]       bus_wdata,
   input logic              lp_exit,
   input logic              fail_det,
   input logic              sec_en,
   input logic [1:0]        sys_sel,
   input logic              irq,
   input logic              fail_q
);

   // R2: a legal software code lands when no hardware force is pending
   a_r2_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(SEL_OFS) && bus_be[0] && bus_wdata[1:0] != 2'b11
       && !lp_exit && !(sec_en && fail_det)) |=> (sys_sel == $past(bus_wdata[1:0])));

   // R3
   a_r3_no_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      sys_sel != 2'b11);

   // R4
   a_r4_lp_fallback: assert property (@(posedge clk) disable iff (!rst_n)
      lp_exit |=> (sys_sel == 2'b00));

   // R5
   a_r5_ext_fallback: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_en && fail_det && sys_sel == 2'b01) |=> (sys_sel == 2'b00));

   // R7
   a_r7_fail_set: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_en && fail_det) |=> fail_q);

   // R11
   a_r11_fail_irq: assert property (@(posedge clk) disable iff (!rst_n)
      fail_q |-> irq);

endmodule

bind clksw_ctrl clksw_ctrl_chk #(.ADDR_W(ADDR_W), .SEL_OFS(SEL_OFS)) u_chk (.*);

// File: tb/clksw_ctrl_bench.sv
module clksw_ctrl_bench;
   localparam int CLK_P = 10;
   localparam int N     = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [3:0]  bus_be = 4'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic [N-1:0] rdy_in = '0;
   logic        fail_det = 1'b0, sec_en = 1'b0, pll_on_ext = 1'b0, lp_exit = 1'b0;
   logic [1:0]  sys_sel;
   logic        irq;

   always #(CLK_P/2) clk = ~clk;

   clksw_ctrl u_clksw_ctrl (.*);

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // reference state
   logic [1:0]   m_sel;
   logic [N-1:0] m_flag, m_en, m_prev;
   logic         m_fail;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(logic [7:0] a);
      if (a == 8'h04) return {30'h0, m_sel};
      if (a == 8'h08) return {16'h0, 1'b0, m_en, m_fail, m_flag};
      return 32'h0;
   endfunction

   function automatic logic exp_irq();
      return (|(m_flag & m_en)) | m_fail;
   endfunction

   task automatic model_step();
      logic fe, frc, hit8;
      logic [N-1:0] clr;
      if (!rst_n) begin
         m_sel = 2'b00; m_flag = '0; m_en = '0; m_prev = '0; m_fail = 1'b0;
         return;
      end
      fe   = sec_en && fail_det;
      frc  = lp_exit || (fe && (m_sel == 2'b01 || (m_sel == 2'b10 && pll_on_ext)));
      hit8 = bus_wr && bus_addr == 8'h08;
      if (bus_wr && bus_addr == 8'h04 && bus_be[0] && bus_wdata[1:0] != 2'b11)
         m_sel = bus_wdata[1:0];
      if (frc) m_sel = 2'b00;
      clr    = (hit8 && bus_be[2]) ? bus_wdata[22:16] : '0;
      m_flag = (m_flag & ~clr) | (rdy_in & ~m_prev);
      if (hit8 && bus_be[2] && bus_wdata[23]) m_fail = 1'b0;
      if (fe) m_fail = 1'b1;
      if (hit8 && bus_be[1]) m_en = bus_wdata[14:8];
      m_prev = rdy_in;
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
      tick();
      bus_wr = 1'b0; bus_be = 4'h0;
   endtask

   task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
      bus_addr = a; #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic pulse_fail();
      fail_det = 1'b1; tick(); fail_det = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      chk("R1 sel", {30'h0, sys_sel}, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);
      rd_chk("R1 evreg", 8'h08, 32'h0);
      rd_chk("R1 selreg", 8'h04, 32'h0);

      // R2 software selection
      wr(8'h04, 4'h1, 32'h1);
      chk("R2 ext", {30'h0, sys_sel}, 32'h1);
      rd_chk("R2 readback", 8'h04, 32'h1);
      wr(8'h04, 4'h1, 32'hFFFF_FFF2);
      rd_chk("R2 pll readback", 8'h04, 32'h2);

      // R3 illegal code dropped
      wr(8'h04, 4'h1, 32'h3);
      chk("R3 keep", {30'h0, sys_sel}, 32'h2);

      // R12 lane 0 disabled
      wr(8'h04, 4'hE, 32'h0);
      chk("R12 lane0 off", {30'h0, sys_sel}, 32'h2);

      // R4 low-power exit beats write
      lp_exit = 1'b1;
      wr(8'h04, 4'h1, 32'h1);
      lp_exit = 1'b0;
      chk("R4 forced", {30'h0, sys_sel}, 32'h0);

      // R5 / R7 supervision
      wr(8'h04, 4'h1, 32'h1);
      pulse_fail();
      chk("R5 no sec_en", {30'h0, sys_sel}, 32'h1);
      rd_chk("R7 no flag", 8'h08, 32'h0);
      sec_en = 1'b1; pll_on_ext = 1'b0;
      wr(8'h04, 4'h1, 32'h2);
      pulse_fail();
      chk("R5 pll internal", {30'h0, sys_sel}, 32'h2);
      rd_chk("R7 flag set", 8'h08, 32'h80);
      chk("R11 fail irq", {31'h0, irq}, 32'h1);
      pll_on_ext = 1'b1;
      pulse_fail();
      chk("R5 pll on ext", {30'h0, sys_sel}, 32'h0);
      wr(8'h04, 4'h1, 32'h1);
      pulse_fail();
      chk("R5 ext", {30'h0, sys_sel}, 32'h0);
      wr(8'h08, 4'h4, 32'h0080_0000);
      rd_chk("R9 fail clear", 8'h08, 32'h0);
      chk("R9 irq low", {31'h0, irq}, 32'h0);

      // R6 ready flags
      rdy_in[3] = 1'b1; tick();
      rd_chk("R6 flag3", 8'h08, 32'h08);
      tick();
      wr(8'h08, 4'h4, 32'h0008_0000);
      tick();
      rd_chk("R6 held level", 8'h08, 32'h0);
      rdy_in[0] = 1'b1; tick();
      wr(8'h08, 4'h1, 32'h0000_0000);
      rd_chk("R6 read-only", 8'h08, 32'h01);

      // R8 enables
      wr(8'h08, 4'h2, 32'h0000_FF00);
      rd_chk("R8 enables", 8'h08, 32'h7F01);
      chk("R11 flag&en", {31'h0, irq}, 32'h1);
      wr(8'h08, 4'h1, 32'h0);
      rd_chk("R12 en kept", 8'h08, 32'h7F01);

      // R9 zero writes and reserved bits
      wr(8'h08, 4'h4, 32'h0);
      rd_chk("R9 zero no effect", 8'h08, 32'h7F01);
      wr(8'h08, 4'hF, 32'hFF00_FF00);
      rd_chk("R9 upper zero", 8'h08, 32'h7F01);

      // R10 set and clear together
      rdy_in[5] = 1'b1;
      wr(8'h08, 4'h4, 32'h0020_0000);
      rd_chk("R10 set wins", 8'h08, 32'h7F21);

      // R11 enable gating
      wr(8'h08, 4'h4, 32'h00FF_0000);
      rd_chk("R9 clear all", 8'h08, 32'h7F00);
      wr(8'h08, 4'h2, 32'h0);
      rdy_in[1] = 1'b1; tick();
      rd_chk("R6 flag1", 8'h08, 32'h02);
      chk("R11 gated", {31'h0, irq}, 32'h0);

      // random phase against the reference state
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] a;
         case ($urandom % 3)
            0: a = 8'h04;
            1: a = 8'h08;
            default: a = 8'h0C;
         endcase
         bus_addr = a; bus_wr = 1'b0; #1;
         chk("R2 sel rand", {30'h0, sys_sel}, {30'h0, m_sel});
         chk("R11 irq rand", {31'h0, irq}, {31'h0, exp_irq()});
         chk("R8 read rand", bus_rdata, exp_rd(a));
         for (int b = 0; b < N; b++)
            if ($urandom % 8 == 0) rdy_in[b] = ~rdy_in[b];
         fail_det   = ($urandom % 20 == 0);
         lp_exit    = ($urandom % 30 == 0);
         pll_on_ext = $urandom % 2;
         if ($urandom % 50 == 0) sec_en = ~sec_en;
         bus_wr    = ($urandom % 3 == 0);
         bus_be    = 4'($urandom);
         bus_wdata = $urandom;
         tick();
      end
      bus_wr = 1'b0; fail_det = 1'b0; lp_exit = 1'b0;
      finish_run();
   end
endmodule